// File: doc/BRIEF.md
# Prescaled Dual Timer Unit

This peripheral provides two independent 24-bit down-counting timers. Both draw their count steps from one shared 10-bit prescaler, and a separate 24-bit watchdog register is available as plain storage. Software reaches everything through a simple 32-bit register bus. A write takes effect at the clock edge where it is presented. A read returns its data one cycle after the read strobe, together with a valid flag.

Each timer has a live count, a reload value and a control word. Through the control word software can load the reload value into the counter, start the timer, freeze it, or let it continue from a frozen count. When a timer steps below zero it gives a one-clock interrupt pulse. It then either reloads and keeps running, or it stops and clears its own enable bit. The prescaler counts only while at least one timer is enabled. It issues one tick each time it wraps, and that tick steps both timers together.

Top module: `dtmr_top`

## Requirements
- R1: After reset every register reads 0, both timers are disabled and both interrupt outputs are low.
- R2: A reload register and the watchdog register keep bits 23:0 of a write and read the other bits as 0. The prescaler reload register keeps bits 9:0.
- R3: In a timer's control word, bit 0 is enable, bit 1 is auto-reload and bit 2 is load. A control read returns enable in bit 0, auto-reload in bit 1 and 0 in every other bit, so load always reads back as 0.
- R4: While any timer is enabled, the prescaler ticks once every (P+1) clocks, where P is the prescaler reload value. A timer in auto-reload mode therefore interrupts once every (R+1)·(P+1) clocks, where R is its reload value.
- R5: A control write with load=1 copies the reload value into the counter. With enable=1 the timer then counts. With enable=0 the timer stays stopped, holding that value.
- R6: A control write with load=0 that clears enable freezes the count. A later write with load=0 that sets enable resumes counting from the frozen value. A control write never steps the count in its own cycle.
- R7: A tick that finds an enabled timer at count 0 is an underflow. On the following clock edge the timer's interrupt output is high for exactly that one cycle. With auto-reload set, the counter reloads and keeps running.
- R8: On an underflow with auto-reload clear, the timer stays at 0 and clears its enable bit, which a control read then shows.
- R9: The byte offsets are as follows. Timer 1 has its counter at 0x40, reload at 0x44 and control at 0x48. Timer 2 has its counter at 0x50, reload at 0x54 and control at 0x58. The watchdog is at 0x4C, the prescaler counter at 0x60 and the prescaler reload at 0x64. Read data and the valid flag appear in the cycle after the read strobe.
- R10: Writes to the prescaler counter or to a timer counter address are ignored. A read of any other unmapped address returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | High for the cycle that carries read data |
| irq | output | 2 | One-cycle underflow pulses, bit 0 for timer 1 and bit 1 for timer 2 |

## Verification
The assertions make three assumptions about the inputs: the read and write strobes are never high in the same cycle, addresses are word-aligned, and no input carries an unknown value once reset is released. The stimulus keeps within these limits. It issues exactly one bus operation or one idle cycle per clock, changes inputs only on the falling edge, and uses only aligned offsets. It predicts live counts and interrupt totals by counting prescaler ticks from the edge at which each control write lands.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CNT_W = 24;
    localparam int PRE_W = 10;
    localparam int BUS_W = 32;

    localparam int CTL_EN_BIT = 0;
    localparam int CTL_AR_BIT = 1;
    localparam int CTL_LD_BIT = 2;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             en;
        logic             ar;
        logic             irq;
    } chan_state_t;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] rld;
    } pre_state_t;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             rvalid;
        logic [CNT_W-1:0] wdog;
    } top_state_t;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rld_wr,
    input  logic [PRE_W-1:0] rld_wdata,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W-1:0] rld,
    output logic             tick
);
    pre_state_t st_d, st_q;
    logic       tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = run && (st_q.cnt == '0);
        if (run) begin
            if (tick_d) st_d.cnt = st_q.rld;
            else        st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rld_wr) st_d.rld = rld_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign rld  = st_q.rld;
    assign tick = tick_d;

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.rld != '0) |=> !tick);
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             reload_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             en,
    output logic             ar,
    output logic             irq
);
    chan_state_t st_d, st_q;
    logic        load_wr;

    assign load_wr = ctrl_wr && wdata[CTL_LD_BIT];

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (reload_wr) st_d.reload = wdata[CNT_W-1:0];
        if (ctrl_wr) begin
            st_d.en = wdata[CTL_EN_BIT];
            st_d.ar = wdata[CTL_AR_BIT];
            if (wdata[CTL_LD_BIT]) st_d.count = st_q.reload;
        end else if (tick && st_q.en) begin
            if (st_q.count == '0) begin
                st_d.irq = 1'b1;
                if (st_q.ar) st_d.count = st_q.reload;
                else         st_d.en    = 1'b0;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count  = st_q.count;
    assign reload = st_q.reload;
    assign en     = st_q.en;
    assign ar     = st_q.ar;
    assign irq    = st_q.irq;

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !load_wr) |=> $stable(st_q.count));

    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (st_q.count == $past(st_q.reload)));

    assert_irq_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> ($past(st_q.en) && $past(st_q.count) == '0));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !$past(st_q.ar) && !$past(ctrl_wr)) |-> !st_q.en);
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic [1:0]        irq
);
    localparam int N_TMR      = 2;
    localparam int TMR_BASE   = 'h40;
    localparam int TMR_STRIDE = 'h10;
    localparam int OFS_CNT    = 'h0;
    localparam int OFS_RLD    = 'h4;
    localparam int OFS_CTL    = 'h8;
    localparam logic [ADDR_W-1:0] A_WDOG = ADDR_W'('h4C);
    localparam logic [ADDR_W-1:0] A_PCNT = ADDR_W'('h60);
    localparam logic [ADDR_W-1:0] A_PRLD = ADDR_W'('h64);

    logic [CNT_W-1:0] t_count  [N_TMR];
    logic [CNT_W-1:0] t_reload [N_TMR];
    logic [N_TMR-1:0] t_en, t_ar, t_irq;
    logic [PRE_W-1:0] p_cnt, p_rld;
    logic             p_tick;
    logic             rd_hit;
    logic [BUS_W-1:0] rd_val;

    top_state_t st_d, st_q;

    dtmr_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (|t_en),
        .rld_wr    (bus_wr && bus_addr == A_PRLD),
        .rld_wdata (bus_wdata[PRE_W-1:0]),
        .cnt       (p_cnt),
        .rld       (p_rld),
        .tick      (p_tick)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(TMR_BASE + TMR_STRIDE*g + OFS_RLD);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(TMR_BASE + TMR_STRIDE*g + OFS_CTL);

        dtmr_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (p_tick),
            .ctrl_wr   (bus_wr && bus_addr == A_CTL),
            .reload_wr (bus_wr && bus_addr == A_RLD),
            .wdata     (bus_wdata),
            .count     (t_count[g]),
            .reload    (t_reload[g]),
            .en        (t_en[g]),
            .ar        (t_ar[g]),
            .irq       (t_irq[g])
        );
    end

    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < N_TMR; i++) begin
            if (bus_addr == ADDR_W'(TMR_BASE + TMR_STRIDE*i + OFS_CNT)) begin
                rd_val = BUS_W'(t_count[i]);
                rd_hit = 1'b1;
            end
            if (bus_addr == ADDR_W'(TMR_BASE + TMR_STRIDE*i + OFS_RLD)) begin
                rd_val = BUS_W'(t_reload[i]);
                rd_hit = 1'b1;
            end
            if (bus_addr == ADDR_W'(TMR_BASE + TMR_STRIDE*i + OFS_CTL)) begin
                rd_val = BUS_W'({t_ar[i], t_en[i]});
                rd_hit = 1'b1;
            end
        end
        if (bus_addr == A_WDOG) begin
            rd_val = BUS_W'(st_q.wdog);
            rd_hit = 1'b1;
        end
        if (bus_addr == A_PCNT) begin
            rd_val = BUS_W'(p_cnt);
            rd_hit = 1'b1;
        end
        if (bus_addr == A_PRLD) begin
            rd_val = BUS_W'(p_rld);
            rd_hit = 1'b1;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        st_d.rdata  = bus_rd ? rd_val : '0;
        if (bus_wr && bus_addr == A_WDOG) st_d.wdog = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign irq        = t_irq;

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0));

    assert_prescaler_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_en == '0) |=> $stable(p_cnt));
endmodule

// File: tb/dtmr_top_tb.sv
module dtmr_top_tb;
    localparam time CLK_HALF = 5ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_errors = 0;
    int n_irq0   = 0;
    int n_irq1   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #CLK_HALF clk = ~clk;

    dtmr_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever read data is valid.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq[0]) n_irq0++;
            if (irq[1]) n_irq1++;
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected read data", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_rd    = 1'b0;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_rd   = 1'b1;
        bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {30'd0, irq}, 32'd0);
        rd(8'h48, 32'h0, "R1 ctrl1 reset");
        rd(8'h40, 32'h0, "R1 count1 reset");
        rd(8'h58, 32'h0, "R1 ctrl2 reset");
        rd(8'h64, 32'h0, "R1 prescaler reload reset");
        rd(8'h4C, 32'h0, "R1 watchdog reset");

        // R2 masks
        wr(8'h44, 32'hFF12_3456);
        wr(8'h4C, 32'hABCD_EF12);
        wr(8'h64, 32'hFFFF_F7FF);
        rd(8'h44, 32'h0012_3456, "R2 reload1 mask");
        rd(8'h4C, 32'h00CD_EF12, "R2 watchdog mask");
        rd(8'h64, 32'h0000_03FF, "R2 prescaler reload mask");
        wr(8'h64, 32'h0);
        wr(8'h44, 32'h5);

        // R5 load without enable, R3 load bit reads 0
        wr(8'h48, 32'h4);
        rd(8'h40, 32'h5, "R5 load stopped count");
        rd(8'h48, 32'h0, "R3 load bit not stored");
        idle(3);
        rd(8'h40, 32'h5, "R5 stopped count holds");

        // R5 load+enable, live count, R8 one-shot
        wr(8'h48, 32'h5);
        n_irq0 = 0;
        idle(2);
        rd(8'h40, 32'h3, "R5 live count after two ticks");
        rd(8'h48, 32'h1, "R3 enable reads back");
        idle(5);
        check("R7 one-shot irq count", n_irq0, 1);
        rd(8'h48, 32'h0, "R8 enable cleared on underflow");
        rd(8'h40, 32'h0, "R8 count stays zero");

        // R4/R7 auto-reload with prescaler 2, reload 3: period 12
        wr(8'h44, 32'h3);
        wr(8'h64, 32'h2);
        wr(8'h48, 32'h7);
        n_irq0 = 0; n_irq1 = 0;
        idle(100);
        check("R4 auto-reload irq count in 100 clocks", n_irq0, 8);
        check("R7 timer2 quiet", n_irq1, 0);
        rd(8'h48, 32'h3, "R3 enable and auto-reload read back");

        // settle prescaler to zero, then stop timer1
        wr(8'h64, 32'h0);
        idle(3);
        wr(8'h48, 32'h0);

        // R6 freeze / resume on timer2
        wr(8'h54, 32'd10);
        wr(8'h58, 32'h5);
        idle(3);
        wr(8'h58, 32'h0);
        idle(5);
        rd(8'h50, 32'd7, "R6 frozen count");
        rd(8'h58, 32'h0, "R6 enable cleared by freeze");
        wr(8'h58, 32'h1);
        idle(2);
        rd(8'h50, 32'd5, "R6 resumed from frozen count");

        // R5 load while running, one-shot to underflow
        wr(8'h58, 32'h5);
        n_irq1 = 0;
        rd(8'h50, 32'd10, "R5 reload while running");
        idle(14);
        check("R8 timer2 single irq", n_irq1, 1);
        rd(8'h58, 32'h0, "R8 timer2 stopped");

        // R10 ignored writes, unmapped reads
        wr(8'h64, 32'h5);
        wr(8'h60, 32'h155);
        rd(8'h60, 32'h0, "R10 prescaler counter write ignored");
        rd(8'h64, 32'h5, "R9 prescaler reload address");
        wr(8'h50, 32'h1234);
        rd(8'h50, 32'h0, "R10 counter write ignored");
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h5C, 32'h0, "R10 unmapped read zero");
        rd(8'h68, 32'h0, "R10 unmapped read zero high");
        rd(8'h4C, 32'h00CD_EF12, "R10 unmapped write harmless");

        // R4 prescaler 3, reload 1: period 8
        wr(8'h64, 32'h3);
        wr(8'h54, 32'h1);
        wr(8'h58, 32'h7);
        n_irq0 = 0; n_irq1 = 0;
        idle(40);
        check("R4 prescaled irq count in 40 clocks", n_irq1, 5);
        check("R6 frozen timer1 stays quiet", n_irq0, 0);
        rd(8'h54, 32'h1, "R9 reload2 address");

        idle(3);
        check("R9 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule